// File: doc/BRIEF.md
# Length-Framed Serial Packet Receiver

This block sits after a byte-wide serial receiver and collects framed packets in a local buffer. Each frame begins with a destination byte and a payload-length byte. The payload follows, and then one check byte. The block reads the frame's total size from the length byte as soon as that byte arrives. It keeps storing bytes until the frame is whole. It then offers the buffer to a downstream consumer, which either has a slot free or does not.

Bytes can carry a framing, overrun or parity flag. Frames can also be too long for the buffer, and bytes can arrive while a finished packet is still held. In each of these cases the block moves to a discard state and steps a saturating error counter. In the discard state it throws away the rest of the bad frame. It stays there until the line has been quiet for a set number of clocks, then starts afresh at the head of the buffer.

Top module: `rxf_len_rx`

## Requirements
- R1: After reset, `mode` is 0 (collecting), `pkt_done` is 0, and all four counters are 0.
- R2: A frame is a destination byte, a length byte L, L payload bytes and one check byte, L+3 bytes in all. When the last byte of the frame is taken with `slot_free`=1, the following occur in the next cycle: `pkt_done` is high for exactly one cycle, `pkt_len` is L+3, `mode` is 2 (holding), and `cnt_pkts` rises by one. Buffer address i on `rd_addr`/`rd_data` holds the i-th byte of the frame, counting from 0.
- R3: If L+3 is greater than or equal to BUF_SIZE-1, then in the cycle after the length byte `mode` is 1 (discarding) and `cnt_content` rises by one.
- R4: A byte whose `rx_ferr`, `rx_oerr` or `rx_perr` is set, taken in any mode, raises `cnt_io` by one and sets `mode` to 1. This check has priority over every other handling of the byte.
- R5: While `mode` is 1, clean bytes are discarded with no counter change. Each received byte restarts the idle count, so bytes spaced fewer than IDLE_LIMIT idle clocks apart keep `mode` at 1.
- R6: While `mode` is 1, IDLE_LIMIT+1 or more clocks with no byte return `mode` to 0. The next frame is then stored from buffer address 0.
- R7: When a frame completes with `slot_free`=0, `cnt_nobuf` rises by one, `pkt_done` stays 0, `mode` stays 0, and the next frame is stored from address 0.
- R8: A clean byte taken while `mode` is 2 raises `cnt_nobuf` by one and sets `mode` to 1.
- R9: `pkt_release` while `mode` is 2 returns `mode` to 0 and rewinds the buffer. In modes 0 and 1, `pkt_release` has no effect on the frame being collected.
- R10: Every counter is CNT_W bits wide and stops at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error flag of the byte |
| rx_oerr | input | 1 | Overrun error flag of the byte |
| rx_perr | input | 1 | Parity error flag of the byte |
| slot_free | input | 1 | Downstream can take a completed frame |
| pkt_release | input | 1 | Downstream has finished with the held frame |
| rd_addr | input | $clog2(BUF_SIZE) | Buffer read address |
| rd_data | output | 8 | Buffer byte at rd_addr |
| pkt_done | output | 1 | One-cycle pulse when a frame is handed off |
| pkt_len | output | $clog2(BUF_SIZE+1) | Length of the handed-off frame |
| mode | output | 2 | 0 collecting, 1 discarding, 2 holding |
| cnt_io | output | CNT_W | Line error count |
| cnt_content | output | CNT_W | Oversize frame count |
| cnt_nobuf | output | CNT_W | No-slot count |
| cnt_pkts | output | CNT_W | Packets handed off |

## Verification
The bench sends frames whose lengths fall on both sides of the size limit. A design with an off-by-one in that comparison would either reject the largest legal frame or store one byte past the limit. It also completes frames with no downstream slot and then checks that the next frame lands at address 0. A design that failed to rewind would store that frame at a shifted address. Line errors are injected while collecting, while discarding and while holding, to confirm they take priority. The idle return is probed on both sides of the threshold: a timer that was not cleared by skipped bytes would return to collecting too early. Long bursts of errors check that the counters stop at their maximum instead of wrapping to zero.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef enum logic [1:0] {
      MODE_READ = 2'd0,
      MODE_SKIP = 2'd1,
      MODE_MSG  = 2'd2
   } rx_mode_e;

   localparam int CI_IO      = 0;
   localparam int CI_CONTENT = 1;
   localparam int CI_NOBUF   = 2;
   localparam int CI_PKTS    = 3;
   localparam int N_CNT      = 4;
endpackage

// File: rtl/rxf_sat_cnt.sv
module rxf_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   if (W < 2) begin : g_bad_w
      $error("rxf_sat_cnt: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (inc && cnt != '1)
         cnt <= cnt + 1'b1;
   end

   // R10: a counter at its top value stays there
   a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      cnt == '1 |=> cnt == '1);
   // R10: no step without a request
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt));
endmodule

// File: rtl/rxf_idle_timer.sv
module rxf_idle_timer #(
   parameter int LIMIT = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic expired
);
   localparam int W = $clog2(LIMIT + 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("rxf_idle_timer: LIMIT must be at least 2");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (cnt != W'(LIMIT))
         cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == W'(LIMIT));

   // R5: a received byte always restarts the idle window
   a_r5_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !expired);
endmodule

// File: rtl/rxf_buf.sv
module rxf_buf #(
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [7:0]               wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [7:0]               rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_len_rx.sv
module rxf_len_rx
   import rxf_pkg::*;
#(
   parameter int BUF_SIZE   = 16,
   parameter int IDLE_LIMIT = 32,
   parameter int CNT_W      = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rx_valid,
   input  logic [7:0]                    rx_byte,
   input  logic                          rx_ferr,
   input  logic                          rx_oerr,
   input  logic                          rx_perr,
   input  logic                          slot_free,
   input  logic                          pkt_release,
   input  logic [$clog2(BUF_SIZE)-1:0]   rd_addr,
   output logic [7:0]                    rd_data,
   output logic                          pkt_done,
   output logic [$clog2(BUF_SIZE+1)-1:0] pkt_len,
   output logic [1:0]                    mode,
   output logic [CNT_W-1:0]              cnt_io,
   output logic [CNT_W-1:0]              cnt_content,
   output logic [CNT_W-1:0]              cnt_nobuf,
   output logic [CNT_W-1:0]              cnt_pkts
);
   localparam int AW = $clog2(BUF_SIZE);
   localparam int LW = $clog2(BUF_SIZE + 1);
   localparam logic [8:0] HDR_LIM = 9'(BUF_SIZE - 1);
   localparam logic [LW-1:0] FULL = LW'(BUF_SIZE);

   if (BUF_SIZE < 4 || BUF_SIZE > 256) begin : g_bad_size
      $error("rxf_len_rx: BUF_SIZE must lie in 4..256");
   end
   if (IDLE_LIMIT < 2) begin : g_bad_idle
      $error("rxf_len_rx: IDLE_LIMIT must be at least 2");
   end

   rx_mode_e      mode_q, mode_n;
   logic [AW-1:0] wptr_q, wptr_n;
   logic [LW-1:0] used_q, used_n;
   logic [LW-1:0] left_q, left_n;
   logic          done_n;
   logic [LW-1:0] len_q, len_n;
   logic          we;
   logic          idle_exp;
   logic          line_err;
   logic [8:0]    total;
   logic [N_CNT-1:0] inc;
   logic [CNT_W-1:0] cnt [N_CNT];

   assign line_err = rx_ferr | rx_oerr | rx_perr;
   assign total    = {1'b0, rx_byte} + 9'd3;

   always_comb begin
      mode_n = mode_q;
      wptr_n = wptr_q;
      used_n = used_q;
      left_n = left_q;
      len_n  = len_q;
      done_n = 1'b0;
      we     = 1'b0;
      inc    = '0;
      if (rx_valid) begin
         if (line_err) begin
            inc[CI_IO] = 1'b1;
            mode_n     = MODE_SKIP;
         end else begin
            unique case (mode_q)
               MODE_READ: begin
                  if (left_q == '0) begin
                     inc[CI_CONTENT] = 1'b1;
                     mode_n          = MODE_SKIP;
                  end else begin
                     we     = 1'b1;
                     wptr_n = wptr_q + 1'b1;
                     used_n = used_q + 1'b1;
                     left_n = left_q - 1'b1;
                     if (used_n == LW'(2) && total >= HDR_LIM) begin
                        inc[CI_CONTENT] = 1'b1;
                        mode_n          = MODE_SKIP;
                     end else begin
                        if (used_n == LW'(2))
                           left_n = LW'(total - 9'd2);
                        if (left_n == '0) begin
                           if (slot_free) begin
                              inc[CI_PKTS] = 1'b1;
                              mode_n       = MODE_MSG;
                              done_n       = 1'b1;
                              len_n        = used_n;
                           end else begin
                              inc[CI_NOBUF] = 1'b1;
                              wptr_n        = '0;
                              used_n        = '0;
                              left_n        = FULL;
                           end
                        end
                     end
                  end
               end
               MODE_SKIP: ;
               default: begin
                  inc[CI_NOBUF] = 1'b1;
                  mode_n        = MODE_SKIP;
               end
            endcase
         end
      end else if ((mode_q == MODE_SKIP && idle_exp) ||
                   (mode_q == MODE_MSG && pkt_release)) begin
         mode_n = MODE_READ;
         wptr_n = '0;
         used_n = '0;
         left_n = FULL;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_READ;
         wptr_q   <= '0;
         used_q   <= '0;
         left_q   <= FULL;
         len_q    <= '0;
         pkt_done <= 1'b0;
      end else begin
         mode_q   <= mode_n;
         wptr_q   <= wptr_n;
         used_q   <= used_n;
         left_q   <= left_n;
         len_q    <= len_n;
         pkt_done <= done_n;
      end
   end

   rxf_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (rx_valid),
      .expired (idle_exp)
   );

   rxf_buf #(.DEPTH(BUF_SIZE)) u_buf (
      .clk   (clk),
      .we    (we),
      .waddr (wptr_q),
      .wdata (rx_byte),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
      rxf_sat_cnt #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc[g]),
         .cnt   (cnt[g])
      );
   end

   assign cnt_io      = cnt[CI_IO];
   assign cnt_content = cnt[CI_CONTENT];
   assign cnt_nobuf   = cnt[CI_NOBUF];
   assign cnt_pkts    = cnt[CI_PKTS];
   assign pkt_len     = len_q;
   assign mode        = mode_q;

   // R4: a flagged byte always lands in discard mode
   a_r4_line_err_skip: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && line_err |=> mode == MODE_SKIP);
   // R2: a hand-off pulse only appears together with the holding mode
   a_r2_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> mode == MODE_MSG);
   // R2: handed-off length fits the header rule
   a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> (pkt_len >= LW'(3) && pkt_len <= LW'(BUF_SIZE - 2)));
   // R5: a byte seen while discarding never completes a frame
   a_r5_skip_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_SKIP && rx_valid |=> !pkt_done && mode == MODE_SKIP);
   // R8: a byte seen while holding forces discard mode
   a_r8_msg_byte: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_MSG && rx_valid |=> mode == MODE_SKIP);
   // R3: an oversize header rejects the frame in the next cycle
   a_r3_oversize: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_READ && rx_valid && !line_err && used_q == LW'(1) &&
      total >= HDR_LIM |=> mode == MODE_SKIP);
endmodule

// File: tb/rxf_len_rx_tb.sv
`timescale 1ns/1ps
module rxf_len_rx_tb;
   localparam int BUF_SIZE = 16;
   localparam int IDLE     = 8;
   localparam int CW       = 6;
   localparam int AW       = $clog2(BUF_SIZE);
   localparam int LW       = $clog2(BUF_SIZE + 1);
   localparam int NVEC     = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic rx_ferr = 1'b0, rx_oerr = 1'b0, rx_perr = 1'b0;
   logic slot_free = 1'b1;
   logic pkt_release = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic pkt_done;
   logic [LW-1:0] pkt_len;
   logic [1:0] mode;
   logic [CW-1:0] cnt_io, cnt_content, cnt_nobuf, cnt_pkts;

   int n_checks = 0, n_fail = 0;
   int e_io = 0, e_cont = 0, e_nob = 0, e_pkt = 0, e_done = 0, n_done = 0;

   always #2 clk = ~clk;

   rxf_len_rx #(.BUF_SIZE(BUF_SIZE), .IDLE_LIMIT(IDLE), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_ferr(rx_ferr), .rx_oerr(rx_oerr), .rx_perr(rx_perr),
      .slot_free(slot_free), .pkt_release(pkt_release),
      .rd_addr(rd_addr), .rd_data(rd_data), .pkt_done(pkt_done),
      .pkt_len(pkt_len), .mode(mode), .cnt_io(cnt_io),
      .cnt_content(cnt_content), .cnt_nobuf(cnt_nobuf), .cnt_pkts(cnt_pkts)
   );

   always @(negedge clk) if (pkt_done) n_done++;

   // vector: [15:8] length byte, [4] slot_free, [1:0] expected mode
   localparam logic [15:0] VEC [NVEC] = '{
      {8'd0,   3'b0, 1'b1, 2'b0, 2'd2},
      {8'd5,   3'b0, 1'b1, 2'b0, 2'd2},
      {8'd11,  3'b0, 1'b1, 2'b0, 2'd2},
      {8'd12,  3'b0, 1'b1, 2'b0, 2'd1},
      {8'd3,   3'b0, 1'b0, 2'b0, 2'd0},
      {8'd200, 3'b0, 1'b1, 2'b0, 2'd1},
      {8'd11,  3'b0, 1'b0, 2'b0, 2'd0},
      {8'd1,   3'b0, 1'b1, 2'b0, 2'd2}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int len, input int i);
      return 8'(len * 3 + i * 5 + 1);
   endfunction

   task automatic send_byte(input logic [7:0] b, input logic [2:0] err);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = b;
      {rx_ferr, rx_oerr, rx_perr} = err;
      @(negedge clk);
      rx_valid = 1'b0;
      {rx_ferr, rx_oerr, rx_perr} = 3'b000;
   endtask

   task automatic chk_counts(input string tag);
      chk({tag, " cnt_io"}, int'(cnt_io), e_io);
      chk({tag, " cnt_content"}, int'(cnt_content), e_cont);
      chk({tag, " cnt_nobuf"}, int'(cnt_nobuf), e_nob);
      chk({tag, " cnt_pkts"}, int'(cnt_pkts), e_pkt);
   endtask

   task automatic chk_buf(input int len, input string tag);
      int bad = 0;
      for (int i = 0; i < len + 3; i++) begin
         logic [7:0] e;
         e = (i == 0) ? 8'hA5 : (i == 1) ? 8'(len) : pat(len, i - 2);
         rd_addr = AW'(i);
         #0.1;
         if (rd_data != e) bad++;
      end
      chk({tag, " buffer contents mismatches"}, bad, 0);
   endtask

   task automatic idle_back(input string tag);
      repeat (IDLE + 3) @(negedge clk);
      chk({tag, " idle return to mode 0"}, int'(mode), 0);
   endtask

   task automatic release_pkt(input string tag);
      @(negedge clk);
      pkt_release = 1'b1;
      @(negedge clk);
      pkt_release = 1'b0;
      chk({tag, " release to mode 0"}, int'(mode), 0);
   endtask

   // sends a frame with length byte len; expm: 2 stored, 0 no slot, 1 oversize
   task automatic send_frame(input int len, input logic slot, input int expm,
                             input string tag);
      slot_free = slot;
      send_byte(8'hA5, 3'b000);
      send_byte(8'(len), 3'b000);
      if (expm == 1) begin
         e_cont++;
         chk({tag, " R3 oversize mode"}, int'(mode), 1);
         for (int i = 0; i < 4; i++) send_byte(pat(len, i), 3'b000);
         chk({tag, " R5 discard mode kept"}, int'(mode), 1);
         chk_counts({tag, " R3/R5"});
         idle_back({tag, " R6"});
      end else begin
         for (int i = 0; i <= len; i++) send_byte(pat(len, i), 3'b000);
         if (expm == 2) begin
            e_pkt++;
            e_done++;
            chk({tag, " R2 pkt_done"}, int'(pkt_done), 1);
            chk({tag, " R2 pkt_len"}, int'(pkt_len), len + 3);
            chk({tag, " R2 mode"}, int'(mode), 2);
            chk_buf(len, {tag, " R2"});
            chk_counts({tag, " R2"});
            release_pkt({tag, " R9"});
         end else begin
            e_nob++;
            chk({tag, " R7 pkt_done"}, int'(pkt_done), 0);
            chk({tag, " R7 mode"}, int'(mode), 0);
            chk_counts({tag, " R7"});
         end
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mode", int'(mode), 0);
      chk("R1 pkt_done", int'(pkt_done), 0);
      chk_counts("R1");

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         send_frame(int'(VEC[v][15:8]), VEC[v][4], int'(VEC[v][1:0]),
                    $sformatf("vec%0d", v));
      end
      // R7 rewind: frame after a no-slot drop starts at address 0
      send_frame(4, 1'b1, 2, "R7 rewind follow-up");

      // R4 line error mid-frame, then R5 discard with spaced bytes
      slot_free = 1'b1;
      send_byte(8'hA5, 3'b000);
      send_byte(8'd4, 3'b001);
      e_io++;
      chk("R4 parity err mode", int'(mode), 1);
      chk_counts("R4 parity");
      for (int i = 0; i < 3; i++) begin
         repeat (IDLE - 2) @(negedge clk);
         send_byte(8'h33, 3'b000);
      end
      repeat (IDLE - 2) @(negedge clk);
      chk("R5 spaced bytes keep discard", int'(mode), 1);
      chk_counts("R5 spaced");
      repeat (4) @(negedge clk);
      chk("R6 idle return", int'(mode), 0);
      send_frame(2, 1'b1, 2, "R6 rewind follow-up");

      // R8 byte while holding
      slot_free = 1'b1;
      send_byte(8'hA5, 3'b000);
      send_byte(8'd0, 3'b000);
      send_byte(8'h11, 3'b000);
      e_pkt++; e_done++;
      chk("R8 setup holding", int'(mode), 2);
      send_byte(8'h22, 3'b000);
      e_nob++;
      chk("R8 byte in holding mode", int'(mode), 1);
      chk_counts("R8");
      idle_back("R8");

      // R4 flagged byte while holding: priority over R8
      send_byte(8'hA5, 3'b000);
      send_byte(8'd0, 3'b000);
      send_byte(8'h11, 3'b000);
      e_pkt++; e_done++;
      send_byte(8'h22, 3'b100);
      e_io++;
      chk("R4 framing err in holding", int'(mode), 1);
      chk_counts("R4 holding");
      send_byte(8'h22, 3'b010);
      e_io++;
      chk_counts("R4 overrun in discard");
      idle_back("R4");

      // R9 release while collecting is ignored
      send_byte(8'hA5, 3'b000);
      send_byte(8'd4, 3'b000);
      @(negedge clk);
      pkt_release = 1'b1;
      @(negedge clk);
      pkt_release = 1'b0;
      chk("R9 release in collect mode", int'(mode), 0);
      for (int i = 0; i <= 4; i++) send_byte(pat(4, i), 3'b000);
      e_pkt++; e_done++;
      chk("R9 frame intact pkt_len", int'(pkt_len), 7);
      chk_buf(4, "R9");
      release_pkt("R9");

      // R10 saturation
      for (int i = 0; i < 70; i++) send_byte(8'h00, 3'b010);
      e_io = (1 << CW) - 1;
      chk("R10 cnt_io saturates", int'(cnt_io), e_io);
      chk_counts("R10");
      idle_back("R10");

      chk("R2 pkt_done pulse count", n_done, e_done);
      finish_run();
   end
endmodule